// File: doc/BRIEF.md
# Paced AXI Address-Command Generator

This block produces a stream of AXI address-channel commands, read or write, from a small set of configuration inputs that are captured when a run starts. After a programmed hold-off it issues a programmed number of transactions. Each transaction address is the previous one plus a fixed stride. The address folds back to a lower window bound whenever the next step would pass the upper bound. Idle gaps of a programmed length separate consecutive handshakes, so the offered bandwidth can be throttled. In write mode the generator also paces the write-data beats, presenting burst length plus one beats with the last one flagged. Data contents and responses are left to the surrounding logic.

The controller is a single state machine with five named states. `ST_IDLE` waits for a start. `ST_DELAY` counts the start hold-off. `ST_ADDR` presents the address command. `ST_DATA` presents one write beat. `ST_GAP` counts the idle cycles that follow a handshake.

The named transitions are as follows. IDLE to DELAY on a start with a legal burst type. DELAY to ADDR when the hold-off expires with work pending. DELAY to IDLE when the hold-off expires with a count of zero. ADDR to DATA or to GAP on a write command handshake. ADDR to ADDR, GAP or IDLE on a read command handshake. DATA to DATA, GAP, ADDR or IDLE on a beat handshake. GAP to its recorded return state when its counter expires.

Top module: `pacegen_top`

## Requirements
- R1: With hold-off value D, `ax_valid` first rises exactly D+1 clock cycles after the edge that samples `start`.
- R2: A run with count N>0 completes exactly N address handshakes. With N=0 no command is issued and `done` still pulses when the hold-off ends.
- R3: The first address equals the start address. Each next address is the previous plus the stride, unless that sum exceeds the upper bound, in which case it is the base address.
- R4: After every handshake that is not the final one of the run, the next valid (address or beat) stays low for exactly G cycles, where G is the gap value. G=0 gives back-to-back transfers.
- R5: In write mode each address handshake is followed by exactly len+1 write beats. `w_last` is high only on the final beat, and `ax_valid` and `w_valid` are never high together.
- R6: `ax_len` carries the 4-bit length zero-extended to 8 bits, and `ax_size` is always 3'b101 (32-byte beats).
- R7: In auto-ID mode the ID is 0 on the first transaction, rises by one per transaction, and returns to 0 after 63. In fixed mode every transaction carries the programmed ID.
- R8: Burst code 2'b01 (INCR) and 2'b10 (WRAP) are issued as programmed. A start with code 2'b00 or 2'b11 sets `cfg_err`, issues nothing and leaves the block idle. The next legal start clears `cfg_err`.
- R9: While a valid is high and its ready is low, the valid stays high and the address, ID, length, burst and `w_last` hold their values.
- R10: A `start` raised while `busy` is high, together with any change on the configuration inputs, has no effect on the run in progress.
- R11: `done` is a one-cycle pulse in the cycle after the final handshake, which is the last address handshake for reads and the last beat handshake for writes. `busy` is low when `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled in idle only) |
| wr_mode | input | 1 | 1: write commands with beats, 0: read commands |
| cfg_txn_count | input | CNT_W | Number of transactions |
| cfg_start_delay | input | CNT_W | Hold-off cycles before first command |
| cfg_gap | input | GAP_W | Idle cycles after each handshake |
| cfg_start_addr | input | ADDR_W | First address |
| cfg_stride | input | ADDR_W | Address increment per transaction |
| cfg_base_addr | input | ADDR_W | Address after a fold-back |
| cfg_high_addr | input | ADDR_W | Upper address bound |
| cfg_len | input | LEN_W | Burst length minus one |
| cfg_burst | input | 2 | Burst type code |
| cfg_id_auto | input | 1 | 1: rolling ID, 0: fixed ID |
| cfg_id_fixed | input | ID_W | ID used in fixed mode |
| ax_valid | output | 1 | Address command valid |
| ax_ready | input | 1 | Address command ready |
| ax_addr | output | ADDR_W | Command address |
| ax_len | output | 8 | Command burst length |
| ax_size | output | 3 | Command beat size |
| ax_burst | output | 2 | Command burst type |
| ax_id | output | ID_W | Command ID |
| w_valid | output | 1 | Write beat valid |
| w_ready | input | 1 | Write beat ready |
| w_last | output | 1 | Final beat of the burst |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Last start carried an illegal burst type |

## Verification
The bench measures the hold-off and gap lengths to the cycle. An off-by-one counter load would shift the first valid or the spacing by one cycle and be reported. Address fold-back is exercised at the exact upper bound and one stride past it: a design that compares with the wrong relation either skips the upper bound or issues an address beyond it. A 66-transaction run crosses the ID wrap, and a design that wraps early or late shows IDs out of sequence. Stalled ready, a start pulse during a run, a zero count and illegal burst codes expose designs that drift their outputs, restart mid-run, hang without `done`, or generate traffic with a bad burst type.

// File: rtl/pacegen_pkg.sv
package pacegen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_ADDR,
        ST_DATA,
        ST_GAP
    } pg_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] BURST_WRAP = 2'b10;
    localparam logic [2:0] SIZE_32B   = 3'b101;

    function automatic logic burst_legal(input logic [1:0] code);
        return (code == BURST_INCR) || (code == BURST_WRAP);
    endfunction

endpackage

// File: rtl/pacegen_cnt.sv
// Loadable down-counter that parks at zero.
module pacegen_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pacegen_addr.sv
// Address walker with fold-back into the base/high window.
module pacegen_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] high_addr,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);
    localparam int SUM_W = ADDR_W + 1;

    logic [ADDR_W-1:0] addr_q, stride_q, base_q, high_q;
    logic [SUM_W-1:0]  sum;
    logic [ADDR_W-1:0] addr_next;

    always_comb begin
        sum       = {1'b0, addr_q} + {1'b0, stride_q};
        addr_next = (sum > {1'b0, high_q}) ? base_q : sum[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
            base_q   <= '0;
            high_q   <= '0;
        end else if (load) begin
            addr_q   <= first_addr;
            stride_q <= stride;
            base_q   <= base_addr;
            high_q   <= high_addr;
        end else if (advance) begin
            addr_q   <= addr_next;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/pacegen_id.sv
// Transaction ID source: rolling or fixed.
module pacegen_id #(
    parameter int ID_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            auto_mode,
    input  logic [ID_W-1:0] fixed_id,
    input  logic            advance,
    output logic [ID_W-1:0] id
);
    localparam logic [ID_W-1:0] ID_TOP = {ID_W{1'b1}};

    logic [ID_W-1:0] id_q;
    logic            auto_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q   <= '0;
            auto_q <= 1'b0;
        end else if (load) begin
            auto_q <= auto_mode;
            id_q   <= auto_mode ? '0 : fixed_id;
        end else if (advance && auto_q) begin
            id_q   <= (id_q == ID_TOP) ? '0 : id_q + 1'b1;
        end
    end

    assign id = id_q;
endmodule

// File: rtl/pacegen_top.sv
module pacegen_top
    import pacegen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 6,
    parameter int CNT_W  = 16,
    parameter int GAP_W  = 8,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_mode,
    input  logic [CNT_W-1:0]  cfg_txn_count,
    input  logic [CNT_W-1:0]  cfg_start_delay,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic [ADDR_W-1:0] cfg_base_addr,
    input  logic [ADDR_W-1:0] cfg_high_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [1:0]        cfg_burst,
    input  logic              cfg_id_auto,
    input  logic [ID_W-1:0]   cfg_id_fixed,
    output logic              ax_valid,
    input  logic              ax_ready,
    output logic [ADDR_W-1:0] ax_addr,
    output logic [7:0]        ax_len,
    output logic [2:0]        ax_size,
    output logic [1:0]        ax_burst,
    output logic [ID_W-1:0]   ax_id,
    output logic              w_valid,
    input  logic              w_ready,
    output logic              w_last,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);
    localparam int LEN_PAD = 8 - LEN_W;

    pg_state_e state_q, state_d, gap_ret_q, gap_tgt;

    logic             start_ok, ax_hs, w_hs;
    logic             gap_go, finish, last_txn, beat_end, txn_dec;
    logic             dly_zero, gap_zero;
    logic [CNT_W-1:0] txn_left_q;
    logic [GAP_W-1:0] gap_q, gap_load_val;
    logic [LEN_W-1:0] len_q, beat_q;
    logic [1:0]       burst_q;
    logic             wr_q, done_q, err_q;

    assign start_ok = (state_q == ST_IDLE) && start && burst_legal(cfg_burst);
    assign ax_hs    = ax_valid && ax_ready;
    assign w_hs     = w_valid && w_ready;
    assign last_txn = (txn_left_q == CNT_W'(1));
    assign beat_end = (beat_q == len_q);
    assign gap_load_val = (gap_q == '0) ? '0 : gap_q - 1'b1;

    // Sub-units
    pacegen_cnt #(.W(CNT_W)) u_delay_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .load_val (cfg_start_delay),
        .zero     (dly_zero)
    );

    pacegen_cnt #(.W(GAP_W)) u_gap_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_go),
        .load_val (gap_load_val),
        .zero     (gap_zero)
    );

    pacegen_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_ok),
        .first_addr (cfg_start_addr),
        .stride     (cfg_stride),
        .base_addr  (cfg_base_addr),
        .high_addr  (cfg_high_addr),
        .advance    (ax_hs),
        .addr       (ax_addr)
    );

    pacegen_id #(.ID_W(ID_W)) u_id (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_ok),
        .auto_mode (cfg_id_auto),
        .fixed_id  (cfg_id_fixed),
        .advance   (ax_hs),
        .id        (ax_id)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        gap_go  = 1'b0;
        gap_tgt = ST_ADDR;
        finish  = 1'b0;
        txn_dec = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) state_d = ST_DELAY;
            end
            ST_DELAY: begin
                if (dly_zero) begin
                    if (txn_left_q == '0) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else begin
                        state_d = ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                if (ax_hs) begin
                    if (wr_q) begin
                        gap_tgt = ST_DATA;
                        gap_go  = 1'b1;
                    end else begin
                        txn_dec = 1'b1;
                        if (last_txn) begin
                            state_d = ST_IDLE;
                            finish  = 1'b1;
                        end else begin
                            gap_tgt = ST_ADDR;
                            gap_go  = 1'b1;
                        end
                    end
                end
            end
            ST_DATA: begin
                if (w_hs) begin
                    if (!beat_end) begin
                        gap_tgt = ST_DATA;
                        gap_go  = 1'b1;
                    end else begin
                        txn_dec = 1'b1;
                        if (last_txn) begin
                            state_d = ST_IDLE;
                            finish  = 1'b1;
                        end else begin
                            gap_tgt = ST_ADDR;
                            gap_go  = 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (gap_zero) state_d = gap_ret_q;
            end
            default: state_d = ST_IDLE;
        endcase
        if (gap_go) state_d = (gap_q == '0) ? gap_tgt : ST_GAP;
    end

    // Run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_ret_q  <= ST_IDLE;
            txn_left_q <= '0;
            gap_q      <= '0;
            len_q      <= '0;
            burst_q    <= BURST_INCR;
            wr_q       <= 1'b0;
            beat_q     <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q <= finish;
            if (gap_go) gap_ret_q <= gap_tgt;
            if (state_q == ST_IDLE && start) err_q <= !burst_legal(cfg_burst);
            if (start_ok) begin
                txn_left_q <= cfg_txn_count;
                gap_q      <= cfg_gap;
                len_q      <= cfg_len;
                burst_q    <= cfg_burst;
                wr_q       <= wr_mode;
            end else if (txn_dec) begin
                txn_left_q <= txn_left_q - 1'b1;
            end
            if (ax_hs) begin
                beat_q <= '0;
            end else if (w_hs && !beat_end) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        ax_valid = (state_q == ST_ADDR);
        w_valid  = (state_q == ST_DATA);
        w_last   = w_valid && beat_end;
        ax_len   = {{LEN_PAD{1'b0}}, len_q};
        ax_size  = SIZE_32B;
        ax_burst = burst_q;
        busy     = (state_q != ST_IDLE);
        done     = done_q;
        cfg_err  = err_q;
    end
endmodule

// File: rtl/pacegen_checker.sv
module pacegen_checker
    import pacegen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ax_valid,
    input logic              ax_ready,
    input logic [ADDR_W-1:0] ax_addr,
    input logic [7:0]        ax_len,
    input logic [1:0]        ax_burst,
    input logic [ID_W-1:0]   ax_id,
    input logic              w_valid,
    input logic              w_ready,
    input logic              w_last,
    input logic              busy,
    input logic              done,
    input logic              cfg_err
);
    assert_hold_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_valid && !ax_ready) |=> (ax_valid && $stable(ax_addr) && $stable(ax_id)
                                     && $stable(ax_len) && $stable(ax_burst)));

    assert_hold_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && !w_ready) |=> (w_valid && $stable(w_last)));

    assert_legal_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ax_valid |-> burst_legal(ax_burst));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!busy && !ax_valid && !w_valid));

    assert_one_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ax_valid && w_valid));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind pacegen_top pacegen_checker #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_pacegen_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ax_valid (ax_valid),
    .ax_ready (ax_ready),
    .ax_addr  (ax_addr),
    .ax_len   (ax_len),
    .ax_burst (ax_burst),
    .ax_id    (ax_id),
    .w_valid  (w_valid),
    .w_ready  (w_ready),
    .w_last   (w_last),
    .busy     (busy),
    .done     (done),
    .cfg_err  (cfg_err)
);

// File: tb/pacegen_top_bench.sv
`timescale 1ns/1ps
module pacegen_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_mode = 1'b0;
    logic [15:0] cfg_txn_count = '0;
    logic [15:0] cfg_start_delay = '0;
    logic [7:0]  cfg_gap = '0;
    logic [31:0] cfg_start_addr = '0, cfg_stride = '0, cfg_base_addr = '0, cfg_high_addr = '0;
    logic [3:0]  cfg_len = '0;
    logic [1:0]  cfg_burst = 2'b01;
    logic        cfg_id_auto = 1'b1;
    logic [5:0]  cfg_id_fixed = '0;
    logic        ax_valid, ax_ready, w_valid, w_ready, w_last, busy, done, cfg_err;
    logic [31:0] ax_addr;
    logic [7:0]  ax_len;
    logic [2:0]  ax_size;
    logic [1:0]  ax_burst;
    logic [5:0]  ax_id;

    pacegen_top u_pacegen_top (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode),
        .cfg_txn_count(cfg_txn_count), .cfg_start_delay(cfg_start_delay), .cfg_gap(cfg_gap),
        .cfg_start_addr(cfg_start_addr), .cfg_stride(cfg_stride),
        .cfg_base_addr(cfg_base_addr), .cfg_high_addr(cfg_high_addr),
        .cfg_len(cfg_len), .cfg_burst(cfg_burst), .cfg_id_auto(cfg_id_auto),
        .cfg_id_fixed(cfg_id_fixed), .ax_valid(ax_valid), .ax_ready(ax_ready),
        .ax_addr(ax_addr), .ax_len(ax_len), .ax_size(ax_size), .ax_burst(ax_burst),
        .ax_id(ax_id), .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
        .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;  // 50 MHz

    int n_chk = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Ready drivers: always ready or toggling
    logic stall_mode = 1'b0, tog = 1'b0;
    initial begin
        ax_ready = 1'b1;
        w_ready  = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            tog      = ~tog;
            ax_ready = stall_mode ? tog : 1'b1;
            w_ready  = stall_mode ? ~tog : 1'b1;
        end
    end

    // Monitor
    int          n_ax, n_w, n_done, first_v, done_cyc;
    logic [31:0] m_addr [0:79];
    logic [5:0]  m_id   [0:79];
    logic [7:0]  m_len  [0:79];
    logic [1:0]  m_burst[0:79];
    logic [2:0]  m_size [0:79];
    int          m_axc  [0:79];
    int          m_wc   [0:79];
    logic        m_wl   [0:79];
    logic        prev_stall = 1'b0;
    logic [31:0] s_addr;
    logic [5:0]  s_id;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_ax = 0; n_w = 0; n_done = 0; first_v = -1; done_cyc = -1;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                check("R9 held command", {ax_valid, ax_addr, ax_id}, {1'b1, s_addr, s_id});
            end
            prev_stall = ax_valid && !ax_ready;
            s_addr = ax_addr;
            s_id   = ax_id;
            if (ax_valid && first_v < 0) first_v = cyc;
            if (ax_valid && ax_ready && n_ax < 80) begin
                m_addr[n_ax] = ax_addr; m_id[n_ax] = ax_id; m_len[n_ax] = ax_len;
                m_burst[n_ax] = ax_burst; m_size[n_ax] = ax_size; m_axc[n_ax] = cyc;
                n_ax++;
            end
            if (w_valid && w_ready && n_w < 80) begin
                m_wl[n_w] = w_last; m_wc[n_w] = cyc;
                n_w++;
            end
            if (done) begin
                n_done++;
                done_cyc = cyc;
            end
        end
    end

    function automatic logic [31:0] step_addr(input logic [31:0] a, input logic [31:0] st,
                                              input logic [31:0] b, input logic [31:0] h);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, st};
        return (s > {1'b0, h}) ? b : s[31:0];
    endfunction

    task automatic launch(input bit wr, input int n, input int d, input int g,
                          input logic [31:0] sa, input logic [31:0] st,
                          input logic [31:0] b, input logic [31:0] h,
                          input logic [3:0] len, input logic [1:0] bt,
                          input bit au, input logic [5:0] fid, output int s);
        @(negedge clk);
        wr_mode = wr; cfg_txn_count = 16'(n); cfg_start_delay = 16'(d); cfg_gap = 8'(g);
        cfg_start_addr = sa; cfg_stride = st; cfg_base_addr = b; cfg_high_addr = h;
        cfg_len = len; cfg_burst = bt; cfg_id_auto = au; cfg_id_fixed = fid;
        clear_mon();
        start = 1'b1;
        s = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (n_done == 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 reset busy", busy, 0);
        check("R11 reset done", done, 0);
        check("R8 reset cfg_err", cfg_err, 0);
        check("R5 reset valids", {ax_valid, w_valid}, 0);
    endtask

    task automatic t_read_wrap();
        int s;
        logic [31:0] a;
        launch(0, 5, 3, 0, 32'h1080, 32'h40, 32'h1000, 32'h10C0, 4'd2, 2'b01, 1, 6'd0, s);
        wait_done();
        check("R1 first valid cycle", 64'(first_v), 64'(s + 5));
        check("R2 handshake count", 64'(n_ax), 5);
        check("R11 single done", 64'(n_done), 1);
        check("R11 done after last handshake", 64'(done_cyc), 64'(m_axc[4] + 1));
        a = 32'h1080;
        for (int i = 0; i < 5; i++) begin
            check("R3 address", m_addr[i], a);
            check("R7 auto id", m_id[i], 64'(i));
            check("R6 len", m_len[i], 8'd2);
            check("R6 size", m_size[i], 3'b101);
            check("R8 INCR code", m_burst[i], 2'b01);
            if (i > 0) check("R4 back-to-back", 64'(m_axc[i] - m_axc[i-1]), 1);
            a = step_addr(a, 32'h40, 32'h1000, 32'h10C0);
        end
        check("R5 no beats on read", 64'(n_w), 0);
    endtask

    task automatic t_write_gap();
        int s;
        launch(1, 2, 0, 2, 32'h200, 32'h100, 32'h200, 32'h300, 4'd1, 2'b10, 0, 6'd9, s);
        wait_done();
        check("R1 zero hold-off", 64'(first_v), 64'(s + 2));
        check("R2 write commands", 64'(n_ax), 2);
        check("R5 beat count", 64'(n_w), 4);
        for (int i = 0; i < 4; i++) check("R5 last flag", m_wl[i], (i % 2) == 1);
        check("R4 gap cmd to beat", 64'(m_wc[0] - m_axc[0]), 3);
        check("R4 gap beat to beat", 64'(m_wc[1] - m_wc[0]), 3);
        check("R4 gap beat to cmd", 64'(m_axc[1] - m_wc[1]), 3);
        check("R3 second address", m_addr[1], 32'h300);
        check("R7 fixed id", {m_id[0], m_id[1]}, {6'd9, 6'd9});
        check("R8 WRAP code", m_burst[1], 2'b10);
        check("R11 done after last beat", 64'(done_cyc), 64'(m_wc[3] + 1));
    endtask

    task automatic t_stall();
        int s;
        logic [31:0] a;
        stall_mode = 1'b1;
        launch(0, 4, 1, 1, 32'h10C0, 32'h40, 32'h1000, 32'h10C0, 4'd0, 2'b01, 1, 6'd0, s);
        wait_done();
        stall_mode = 1'b0;
        check("R2 count under stalls", 64'(n_ax), 4);
        a = 32'h10C0;
        for (int i = 0; i < 4; i++) begin
            check("R3 address under stalls", m_addr[i], a);
            check("R7 id under stalls", m_id[i], 64'(i));
            if (i > 0) check("R4 gap lower bound", 64'(m_axc[i] - m_axc[i-1] >= 2), 1);
            a = step_addr(a, 32'h40, 32'h1000, 32'h10C0);
        end
    endtask

    task automatic t_id_wrap();
        int s;
        launch(0, 66, 0, 0, 32'h0, 32'h20, 32'h0, 32'hFFFF, 4'd0, 2'b01, 1, 6'd0, s);
        wait_done();
        check("R2 long run count", 64'(n_ax), 66);
        check("R7 id before wrap", m_id[63], 6'h3F);
        check("R7 id after wrap", m_id[64], 6'h00);
        check("R7 id second after wrap", m_id[65], 6'h01);
        check("R3 linear address", m_addr[65], 32'(65 * 32));
    endtask

    task automatic t_bad_burst();
        int s;
        launch(0, 2, 0, 0, 32'h0, 32'h20, 32'h0, 32'hFF, 4'd0, 2'b00, 1, 6'd0, s);
        repeat (10) @(negedge clk);
        check("R8 err on code 00", cfg_err, 1);
        check("R8 no traffic on 00", {64'(n_ax), 1'b0, busy}, 0);
        launch(0, 2, 0, 0, 32'h0, 32'h20, 32'h0, 32'hFF, 4'd0, 2'b11, 1, 6'd0, s);
        repeat (10) @(negedge clk);
        check("R8 err on code 11", cfg_err, 1);
        check("R8 no traffic on 11", {64'(n_ax), 1'b0, busy}, 0);
        launch(0, 1, 0, 0, 32'h40, 32'h20, 32'h0, 32'hFF, 4'd0, 2'b01, 1, 6'd0, s);
        wait_done();
        check("R8 err cleared", cfg_err, 0);
        check("R8 legal run issues", 64'(n_ax), 1);
    endtask

    task automatic t_busy_start();
        int s;
        launch(0, 3, 5, 0, 32'h100, 32'h10, 32'h100, 32'h1FF, 4'd0, 2'b01, 1, 6'd0, s);
        @(negedge clk);
        cfg_txn_count = 16'd10; cfg_start_addr = 32'h800; cfg_id_auto = 1'b0;
        cfg_id_fixed = 6'd5; cfg_burst = 2'b11;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check("R10 count unchanged", 64'(n_ax), 3);
        check("R10 address unchanged", m_addr[0], 32'h100);
        check("R10 id unchanged", m_id[2], 6'd2);
        check("R10 no error", cfg_err, 0);
        check("R10 one done", 64'(n_done), 1);
    endtask

    task automatic t_zero_count();
        int s;
        launch(0, 0, 4, 0, 32'h0, 32'h20, 32'h0, 32'hFF, 4'd0, 2'b01, 1, 6'd0, s);
        wait_done();
        check("R2 zero count no command", 64'(n_ax), 0);
        check("R2 zero count done", 64'(done_cyc), 64'(s + 6));
    endtask

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_read_wrap();
        t_write_gap();
        t_stall();
        t_id_wrap();
        t_bad_burst();
        t_busy_start();
        t_zero_count();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule